// File: doc/BRIEF.md
# Two-Wire Sixteen-Bit Port Expander Slave

This block is the serial front end and register file of a sixteen-bit general-purpose I/O expander on a two-wire (I2C) bus. It watches the clock and data lines through synchronisers running on a faster system clock. It detects START, repeated START and STOP conditions, matches a seven-bit device address, and acknowledges the bytes addressed to it. It drives the data line only through an active-low output enable, so the line stays open-drain.

A write transfer carries a command byte that loads an internal register pointer, followed by any number of data bytes. A read transfer, usually issued after a repeated START, returns data from the register the pointer selects. The registers are grouped in pairs whose codes differ only in the least significant bit. Each data byte after the first, in either direction, goes to the other register of the pair. Outputs, polarity inversion and direction configuration are presented as plain sixteen-bit vectors. The input port is sampled from the pins at the moment a byte is loaded for transmission. The bus has no stream handshake: the bus master sets the pace, and the block never stretches the clock.

Top module: `i2cx_expander`

## Requirements
- R1: The device address is the seven bits {0,1,0,0, dev_pins[2], dev_pins[1], dev_pins[0]}, sent most significant bit first and followed by the R/W bit (0 = write, 1 = read). On a match the slave pulls SDA low during the ninth clock. On any other address it leaves SDA released and ignores the bus until the next START.
- R2: In a write transfer, the slave acknowledges the command byte and every data byte by pulling SDA low during the ninth clock.
- R3: Command codes select 8-bit registers: 0/1 are input port low/high, 2/3 are output low/high (out_port[7:0]/[15:8]), 4/5 are polarity low/high (pol_inv), and 6/7 are configuration low/high (cfg_dir). Writes to codes 0 and 1 change nothing.
- R4: The first data byte of a write goes to the register named by the command. Each further byte goes to the register whose code has the least significant bit flipped, and the writes keep alternating within that pair.
- R5: A read returns first the register at the pointer, then alternates with its pair partner for as many bytes as the master acknowledges. A repeated START keeps the pointer that the preceding write set.
- R6: A read of input code 0 or 1 returns the pin byte XOR the matching polarity byte. The value is captured on the SCL falling edge that ends the acknowledge clock before the byte.
- R7: Codes 8 to 255 are acknowledged. Reads of them return 0x00 and writes to them change no register.
- R8: After the master leaves a read byte unacknowledged, the slave keeps SDA released until the next START.
- R9: A STOP at any point, including in the middle of a byte, returns the slave to idle. The partial byte is discarded, and the next transfer is served normally.
- R10: In correctly formed bus traffic, the SDA output enable changes only while SCL is low.
- R11: After reset, SDA is released, out_port = 0xFFFF, pol_inv = 0x0000, cfg_dir = 0xFFFF, and the pointer is 0, so a read with no command returns input port 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| dev_pins | input | 3 | Pin-strapped low address bits |
| gpio_in | input | 16 | Levels on the sixteen I/O pins |
| out_port | output | 16 | Output port register pair |
| pol_inv | output | 16 | Polarity inversion register pair |
| cfg_dir | output | 16 | Direction configuration register pair |

## Verification
The bench builds the block with its defaults: a sixteen-bit port, and so codes 0 to 7, plus two synchroniser stages. In that configuration the whole strap space and the whole real register map are small enough to cover. Every one of the eight strap settings is tried against every address in the 0100 group and against an address outside the group. Every code from 0 to 9 is read over four alternating bytes against values the bench derives from its own model of the register pairs. STOPs are placed in the middle of an address byte and in the middle of a data byte, and extra clocks follow a master NACK.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  localparam int BYTE_W = 8;
  localparam int PIN_W = 3;
  localparam logic [BYTE_W-PIN_W-2:0] DEV_FIXED = 4'b0100;
  localparam int GPIO_W = 16;
  localparam int NIN = GPIO_W / BYTE_W;
  localparam int NBANK = 3 * NIN;
  localparam int NUM_CODES = 4 * NIN;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } link_state_t;
endpackage

// File: rtl/i2cx_sync.sv
module i2cx_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/i2cx_link.sv
module i2cx_link
  import i2cx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [PIN_W-1:0]  dev_pins,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              cmd_wr,
  output logic              data_wr,
  output logic              rd_load,
  output logic [BYTE_W-1:0] wdata
);
  localparam int CNT_W = $clog2(BYTE_W) + 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  link_state_t       state;
  logic              scl_q, sda_q;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              rw_q, first_q, mack_q;
  logic              scl_rise, scl_fall, start_det, stop_det, addr_match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise   = scl_s & ~scl_q;
  assign scl_fall   = ~scl_s & scl_q;
  assign start_det  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det   = scl_s & scl_q & ~sda_q & sda_s;
  assign addr_match = (shreg[BYTE_W-1:1] == {DEV_FIXED, dev_pins});
  assign wdata      = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bitcnt  <= '0;
      rw_q    <= 1'b0;
      first_q <= 1'b0;
      mack_q  <= 1'b0;
      sda_oe  <= 1'b0;
      cmd_wr  <= 1'b0;
      data_wr <= 1'b0;
      rd_load <= 1'b0;
    end else begin
      cmd_wr  <= 1'b0;
      data_wr <= 1'b0;
      rd_load <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        shreg  <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR, ST_RX: begin
            if (scl_rise && bitcnt != FULL) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              bitcnt <= '0;
              if (state == ST_ADDR) begin
                if (addr_match) begin
                  sda_oe  <= 1'b1;
                  rw_q    <= shreg[0];
                  first_q <= 1'b1;
                  state   <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                sda_oe  <= 1'b1;
                cmd_wr  <= first_q;
                data_wr <= ~first_q;
                first_q <= 1'b0;
                state   <= ST_RX_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw_q) begin
                rd_load <= 1'b1;
                shreg   <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                state   <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= ST_RX;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
                state  <= ST_TX_ACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack_q <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_q) begin
                rd_load <= 1'b1;
                shreg   <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                state   <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_oe && state == ST_IDLE));
  a_r1_ack_match: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_ACK) |-> addr_match);
  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);
endmodule

// File: rtl/i2cx_regfile.sv
module i2cx_regfile
  import i2cx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GPIO_W-1:0] gpio_s,
  input  logic              cmd_wr,
  input  logic              data_wr,
  input  logic              rd_load,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_data,
  output logic [GPIO_W-1:0] out_port,
  output logic [GPIO_W-1:0] pol_inv,
  output logic [GPIO_W-1:0] cfg_dir
);
  logic [BYTE_W-1:0]             ptr;
  logic [NBANK-1:0][BYTE_W-1:0]  bank;
  logic [NIN-1:0][BYTE_W-1:0]    in_bytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (cmd_wr) begin
      ptr <= wdata;
    end else if (data_wr || rd_load) begin
      ptr[0] <= ~ptr[0];
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    localparam logic [BYTE_W-1:0] CODE = BYTE_W'(g + NIN);
    localparam logic [BYTE_W-1:0] RSTV = (g >= NIN && g < 2 * NIN) ? '0 : '1;
    logic [BYTE_W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= RSTV;
      else if (data_wr && ptr == CODE) r <= wdata;
    end
    assign bank[g] = r;
  end

  for (genvar g = 0; g < NIN; g++) begin : g_in
    assign in_bytes[g] = gpio_s[g*BYTE_W +: BYTE_W] ^ bank[NIN + g];
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NIN; k++)
      if (ptr == BYTE_W'(k)) rd_data = in_bytes[k];
    for (int k = 0; k < NBANK; k++)
      if (ptr == BYTE_W'(k + NIN)) rd_data = bank[k];
  end

  assign out_port = bank[NIN-1:0];
  assign pol_inv  = bank[2*NIN-1:NIN];
  assign cfg_dir  = bank[3*NIN-1:2*NIN];

  a_r7_absent_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && ptr >= BYTE_W'(NUM_CODES)) |=> $stable(bank));
  a_r4_pair_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr || rd_load) |=> (ptr[BYTE_W-1:1] == $past(ptr[BYTE_W-1:1])));
endmodule

// File: rtl/i2cx_expander.sv
module i2cx_expander
  import i2cx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [PIN_W-1:0]  dev_pins,
  input  logic [GPIO_W-1:0] gpio_in,
  output logic [GPIO_W-1:0] out_port,
  output logic [GPIO_W-1:0] pol_inv,
  output logic [GPIO_W-1:0] cfg_dir
);
  logic              scl_s, sda_s;
  logic [GPIO_W-1:0] gpio_s;
  logic              cmd_wr, data_wr, rd_load;
  logic [BYTE_W-1:0] wdata, rd_data;

  i2cx_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  i2cx_sync #(.WIDTH(GPIO_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(gpio_in), .q(gpio_s)
  );

  i2cx_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .dev_pins(dev_pins), .rd_data(rd_data), .sda_oe(sda_oe),
    .cmd_wr(cmd_wr), .data_wr(data_wr), .rd_load(rd_load), .wdata(wdata)
  );

  i2cx_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .gpio_s(gpio_s), .cmd_wr(cmd_wr),
    .data_wr(data_wr), .rd_load(rd_load), .wdata(wdata), .rd_data(rd_data),
    .out_port(out_port), .pol_inv(pol_inv), .cfg_dir(cfg_dir)
  );

  a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wr, data_wr, rd_load}));
endmodule

// File: tb/tb_i2cx_expander.sv
module tb_i2cx_expander;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [2:0]  pins = 3'd0;
  logic [15:0] gpio = 16'h0000;
  logic        sda_oe;
  logic [15:0] out_port, pol_inv, cfg_dir;
  wire         sda_line = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;
  int viol = 0;
  logic oe_prev = 1'b0;
  logic [7:0] mdl [0:7];

  i2cx_expander dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .dev_pins(pins), .gpio_in(gpio),
    .out_port(out_port), .pol_inv(pol_inv), .cfg_dir(cfg_dir)
  );

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) viol++;
    oe_prev = sda_oe;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qwait();
      scl_m = 1'b1; qwait(); qwait();
      scl_m = 1'b0; qwait();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    ack = !sda_line; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait();
      scl_m = 1'b1; qwait();
      b[i] = sda_line; qwait();
      scl_m = 1'b0; qwait();
    end
    sda_m = ~mack; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] c);
    if (c == 8'd0) return gpio[7:0] ^ mdl[4];
    if (c == 8'd1) return gpio[15:8] ^ mdl[5];
    if (c < 8'd8) return mdl[c[2:0]];
    return 8'h00;
  endfunction

  task automatic check_outputs(input string tag);
    check(out_port == {mdl[3], mdl[2]}, tag, out_port, {mdl[3], mdl[2]});
    check(pol_inv == {mdl[5], mdl[4]}, tag, pol_inv, {mdl[5], mdl[4]});
    check(cfg_dir == {mdl[7], mdl[6]}, tag, cfg_dir, {mdl[7], mdl[6]});
  endtask

  task automatic wr_regs(input logic [7:0] cmd, input int n, input logic [7:0] d0,
                         input logic [7:0] d1, input logic [7:0] d2, input string tag);
    bit ack;
    logic [7:0] p;
    logic [7:0] b;
    bus_start();
    send_byte({4'b0100, pins, 1'b0}, ack);
    check(ack, "R1 address ack", ack, 1);
    send_byte(cmd, ack);
    check(ack, "R2 command ack", ack, 1);
    p = cmd;
    for (int k = 0; k < n; k++) begin
      b = (k == 0) ? d0 : (k == 1) ? d1 : d2;
      send_byte(b, ack);
      check(ack, "R2 data ack", ack, 1);
      if (p >= 8'd2 && p < 8'd8) mdl[p[2:0]] = b;
      p[0] = ~p[0];
    end
    bus_stop();
    check_outputs(tag);
  endtask

  task automatic rd_seq(input logic [7:0] code);
    bit ack;
    logic [7:0] b;
    logic [7:0] c;
    string tag;
    tag = (code < 8'd2) ? "R6 input read" : (code >= 8'd8) ? "R7 absent read" : "R5 pair read";
    bus_start();
    send_byte({4'b0100, pins, 1'b0}, ack);
    send_byte(code, ack);
    check(ack, "R7 command ack", ack, 1);
    bus_start();
    send_byte({4'b0100, pins, 1'b1}, ack);
    check(ack, "R5 read address ack", ack, 1);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k < 3, b);
      c = (k % 2 == 0) ? code : (code ^ 8'd1);
      check(b == exp_rd(c), tag, b, exp_rd(c));
    end
    bus_stop();
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    mdl[0] = 8'h00; mdl[1] = 8'h00;
    mdl[2] = 8'hFF; mdl[3] = 8'hFF;
    mdl[4] = 8'h00; mdl[5] = 8'h00;
    mdl[6] = 8'hFF; mdl[7] = 8'hFF;
    gpio = 16'h3C96;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    qwait();

    // R11 reset state
    check(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
    check_outputs("R11 reset values");
    bus_start();
    send_byte({4'b0100, pins, 1'b1}, ack);
    recv_byte(1'b0, b);
    bus_stop();
    check(b == 8'h96, "R11 pointer zero", b, 8'h96);

    // R1 strap and address sweep
    for (int p = 0; p < 8; p++) begin
      pins = 3'(p);
      for (int a = 0; a < 8; a++) begin
        bus_start();
        send_byte({4'b0100, 3'(a), 1'b0}, ack);
        bus_stop();
        check(ack == (a == p), "R1 address match", ack, (a == p));
      end
      bus_start();
      send_byte({4'b0110, 3'(p), 1'b0}, ack);
      bus_stop();
      check(ack == 1'b0, "R1 wrong fixed bits", ack, 0);
    end
    pins = 3'd5;

    // R3 R4 writes
    wr_regs(8'd2, 2, 8'h12, 8'h34, 8'h00, "R4 write out pair");
    wr_regs(8'd3, 2, 8'hAB, 8'hCD, 8'h00, "R4 write odd first");
    wr_regs(8'd4, 2, 8'h0F, 8'hF0, 8'h00, "R4 write polarity");
    wr_regs(8'd7, 2, 8'h55, 8'hAA, 8'h00, "R4 write config");
    wr_regs(8'd5, 3, 8'h01, 8'h02, 8'h03, "R4 three byte alternation");
    wr_regs(8'd0, 2, 8'h11, 8'h22, 8'h00, "R3 input write ignored");
    wr_regs(8'd1, 1, 8'h77, 8'h00, 8'h00, "R3 input write ignored");
    // R7 absent codes
    wr_regs(8'd9, 2, 8'h77, 8'h88, 8'h00, "R7 absent write ignored");
    wr_regs(8'hFE, 3, 8'h00, 8'h00, 8'h00, "R7 absent write ignored");

    // R5 R6 R7 reads
    for (int c = 0; c < 10; c++) rd_seq(8'(c));
    gpio = 16'hA5C3;
    qwait();
    rd_seq(8'd0);
    rd_seq(8'd1);

    // R8 master NACK ends transmission
    bus_start();
    send_byte({4'b0100, pins, 1'b0}, ack);
    send_byte(8'd6, ack);
    bus_start();
    send_byte({4'b0100, pins, 1'b1}, ack);
    recv_byte(1'b0, b);
    check(b == mdl[6], "R8 last byte", b, mdl[6]);
    recv_byte(1'b1, b);
    check(b == 8'hFF, "R8 released after nack", b, 8'hFF);
    bus_stop();

    // R9 STOP in the middle of a data byte
    bus_start();
    send_byte({4'b0100, pins, 1'b0}, ack);
    send_byte(8'd3, ack);
    send_bits(8'h00, 4);
    bus_stop();
    check_outputs("R9 partial data discarded");
    // R9 STOP in the middle of an address byte
    bus_start();
    send_bits({4'b0100, pins, 1'b0}, 3);
    bus_stop();
    wr_regs(8'd2, 1, 8'h5A, 8'h00, 8'h00, "R9 transfer after stop");

    check(viol == 0, "R10 sda change while scl high", viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule